// File: doc/BRIEF.md
# Windowed Toggle-Activity Power Estimator

This block estimates the dynamic power of a neighbouring logic module at run time. A set of single-bit probe lines taken from that module feeds one edge counter per channel. Each counter compares its probe with the value it held one clock earlier and counts the differences. A free-running window timer closes a measurement window every `WIN_CYCLES` clocks. At that point it copies every channel count into a snapshot and restarts the live counts. With a 10 ms window, `WIN_CYCLES` is 10 ms times the clock frequency.

After each window a sequential multiply-accumulate handles one channel per clock. It turns the snapshot into a fixed-point activity figure and multiplies it by the channel's capacitance weight, the shared supply-voltage-squared weight, the shared frequency weight and the channel's correction multiplier. The correction multiplier lets a channel stand in for a signal that can toggle faster than half the clock, where some transitions are never sampled. The channel terms are summed, and the total is presented with a one-cycle valid strobe. A host-side register can capture the estimate and read it at a slower rate, for example once per second.

Top module: `toggle_power_est`

## Requirements
- R1: A channel counts exactly one toggle at every rising clock edge at which its probe bit differs from the value sampled at the previous edge.
- R2: Counting is split into consecutive windows of exactly `WIN_CYCLES` clock edges, starting at the first edge after reset release. The edge that closes a window belongs to that window. Every toggle is counted in exactly one window: none is lost and none is counted twice.
- R3: The probe values sampled during reset serve as the previous values for the first edge after release, so a probe that is held steady through reset release produces no toggle.
- R4: Activity for a channel is `cnt * RECIP`, with `AF = clog2(WIN_CYCLES) + 8` fraction bits and `RECIP = floor((2^AF + floor(WIN_CYCLES/2)) / WIN_CYCLES)`.
- R5: All four weights are unsigned 16-bit values with 8 fraction bits. Each channel term is formed by multiplying the activity in this order: capacitance, supply voltage squared, frequency, correction. After each multiply the result is shifted right by 8 bits, discarding the low bits.
- R6: `power_o` is the sum of all channel terms of one window, an unsigned fixed-point value with `AF` fraction bits.
- R7: `power_valid_o` is a single-cycle pulse that rises `NUM_CH` clock edges after the edge that closed the window. `power_o` changes only in the cycle where `power_valid_o` is high.
- R8: While reset is asserted, and in the first cycle after it, `power_o` is 0 and `power_valid_o` is 0.
- R9: A channel that toggles at every edge reaches a count of exactly `WIN_CYCLES` in a window. Its count never exceeds that value.
- R10: A correction multiplier larger than 1.0 scales that channel's term up. For example, 2.0 (0x0200) doubles the term, apart from truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| probe_i | input | NUM_CH | Probe lines, one bit per channel |
| cap_w_i | input | NUM_CH*WGT_W | Per-channel capacitance weights, channel 0 in the low bits |
| vdd2_w_i | input | WGT_W | Shared supply voltage squared weight |
| freq_w_i | input | WGT_W | Shared operating frequency weight |
| corr_w_i | input | NUM_CH*WGT_W | Per-channel correction multipliers, channel 0 in the low bits |
| power_o | output | OUT_W | Power estimate of the last finished window |
| power_valid_o | output | 1 | One-cycle strobe marking a new estimate |

## Verification
The first pattern holds a non-zero probe vector through reset and afterwards. This separates correct seeding of the previous-value registers from seeding them with zero. A single channel flipping on every clock drives the counter to its full-window maximum, and the resulting estimate exposes any toggle that is dropped or counted twice at the window boundary. Channels toggling at different divided rates, followed by a pseudo-random pattern, give each channel a different count, so a channel-select or summing error shows up in the total. Changing the shared weights and one correction multiplier between windows shows that each weight enters its own multiply stage with the right shift.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

   // accumulation sequencer states
   typedef enum logic {
      MAC_IDLE = 1'b0,
      MAC_RUN  = 1'b1
   } mac_state_e;

   // number of weight stages applied to each channel's activity
   localparam int unsigned N_STAGES = 4;

   // fraction bits of the activity figure for a given window length
   function automatic int unsigned act_frac_bits(input int unsigned win);
      return $clog2(win) + 8;
   endfunction

endpackage

// File: rtl/tpe_window_timer.sv
module tpe_window_timer #(
   parameter int unsigned WIN_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst,
   output logic win_end_o
);
   localparam int unsigned TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

   logic [TW-1:0] tick_q;

   assign win_end_o = (tick_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_q <= '0;
      end else if (win_end_o) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + TW'(1);
      end
   end
endmodule

// File: rtl/tpe_edge_counter.sv
module tpe_edge_counter #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             probe_i,
   input  logic             win_end_i,
   output logic [CNT_W-1:0] live_o,
   output logic [CNT_W-1:0] snap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             last_q;
   logic             flip;
   logic [CNT_W-1:0] live_q;
   logic [CNT_W-1:0] snap_q;
   logic [CNT_W-1:0] next_cnt;

   assign flip = probe_i ^ last_q;

   generate
      if (SATURATE) begin : g_sat
         assign next_cnt = (flip && (live_q == CNT_MAX)) ? live_q
                                                        : live_q + CNT_W'(flip);
      end else begin : g_wrap
         assign next_cnt = live_q + CNT_W'(flip);
      end
   endgenerate

   // previous-value register follows the probe also during reset
   always_ff @(posedge clk) begin
      last_q <= probe_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= '0;
         snap_q <= '0;
      end else if (win_end_i) begin
         snap_q <= next_cnt;
         live_q <= '0;
      end else begin
         live_q <= next_cnt;
      end
   end

   assign live_o = live_q;
   assign snap_o = snap_q;
endmodule

// File: rtl/tpe_mac.sv
module tpe_mac
   import tpe_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned WGT_W      = 16,
   parameter int unsigned WGT_FRAC   = 8,
   parameter int unsigned OUT_W      = 64,
   parameter int unsigned MUL_W      = 80,
   parameter longint unsigned RECIP  = 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start_i,
   input  logic [NUM_CH*CNT_W-1:0]   snap_i,
   input  logic [NUM_CH*WGT_W-1:0]   cap_w_i,
   input  logic [WGT_W-1:0]          vdd2_w_i,
   input  logic [WGT_W-1:0]          freq_w_i,
   input  logic [NUM_CH*WGT_W-1:0]   corr_w_i,
   output logic                      busy_o,
   output logic [OUT_W-1:0]          power_o,
   output logic                      valid_o
);
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

   mac_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [OUT_W-1:0]  acc_q;
   logic [OUT_W-1:0]  power_q;
   logic              valid_q;

   logic [CNT_W-1:0]  snap_arr [NUM_CH];
   logic [WGT_W-1:0]  cap_arr  [NUM_CH];
   logic [WGT_W-1:0]  corr_arr [NUM_CH];
   logic [WGT_W-1:0]  stage_w  [N_STAGES];
   logic [MUL_W-1:0]  chain;
   logic [OUT_W-1:0]  term;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
         assign snap_arr[c] = snap_i[c*CNT_W +: CNT_W];
         assign cap_arr[c]  = cap_w_i[c*WGT_W +: WGT_W];
         assign corr_arr[c] = corr_w_i[c*WGT_W +: WGT_W];
      end
   endgenerate

   // stage order: capacitance, supply squared, frequency, correction
   assign stage_w[0] = cap_arr[idx_q];
   assign stage_w[1] = vdd2_w_i;
   assign stage_w[2] = freq_w_i;
   assign stage_w[3] = corr_arr[idx_q];

   always_comb begin
      chain = MUL_W'(snap_arr[idx_q]) * MUL_W'(RECIP);
      for (int k = 0; k < int'(N_STAGES); k++) begin
         chain = (chain * MUL_W'(stage_w[k])) >> WGT_FRAC;
      end
      term = OUT_W'(chain);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= MAC_IDLE;
         idx_q   <= '0;
         acc_q   <= '0;
         power_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_i) begin
            state_q <= MAC_RUN;
            idx_q   <= '0;
            acc_q   <= '0;
         end else if (state_q == MAC_RUN) begin
            if (idx_q == LAST_IDX) begin
               power_q <= acc_q + term;
               valid_q <= 1'b1;
               state_q <= MAC_IDLE;
               idx_q   <= '0;
            end else begin
               acc_q <= acc_q + term;
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   assign busy_o  = (state_q == MAC_RUN);
   assign power_o = power_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/toggle_power_est.sv
module toggle_power_est
   import tpe_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned WIN_CYCLES = 1000000,
   parameter int unsigned WGT_W      = 16,
   parameter int unsigned WGT_FRAC   = 8,
   parameter int unsigned OUT_W      = 64,
   parameter bit          SATURATE   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH-1:0]       probe_i,
   input  logic [NUM_CH*WGT_W-1:0] cap_w_i,
   input  logic [WGT_W-1:0]        vdd2_w_i,
   input  logic [WGT_W-1:0]        freq_w_i,
   input  logic [NUM_CH*WGT_W-1:0] corr_w_i,
   output logic [OUT_W-1:0]        power_o,
   output logic                    power_valid_o
);
   localparam int unsigned CNT_W    = $clog2(WIN_CYCLES + 1);
   localparam int unsigned ACT_FRAC = act_frac_bits(WIN_CYCLES);
   localparam longint unsigned RECIP =
      ((64'd1 << ACT_FRAC) + 64'(WIN_CYCLES / 2)) / 64'(WIN_CYCLES);
   localparam int unsigned TERM_W   = ACT_FRAC + 1 + N_STAGES * (WGT_W - WGT_FRAC);
   localparam int unsigned SUM_W    = TERM_W + $clog2(NUM_CH);
   localparam int unsigned MUL_W    = TERM_W + WGT_W;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("toggle_power_est: NUM_CH must be at least 1");
      end
      if (WIN_CYCLES < NUM_CH + 2) begin : g_bad_win
         $error("toggle_power_est: window shorter than the accumulation pass");
      end
      if (WGT_FRAC >= WGT_W) begin : g_bad_wgt
         $error("toggle_power_est: weight fraction must be narrower than weight");
      end
      if (ACT_FRAC > 60) begin : g_bad_frac
         $error("toggle_power_est: window too long for 64-bit reciprocal");
      end
      if (SUM_W > OUT_W) begin : g_bad_out
         $error("toggle_power_est: OUT_W cannot hold the summed estimate");
      end
   endgenerate

   logic                    win_end;
   logic                    busy;
   logic [NUM_CH*CNT_W-1:0] live_flat;
   logic [NUM_CH*CNT_W-1:0] snap_flat;

   tpe_window_timer #(
      .WIN_CYCLES (WIN_CYCLES)
   ) i_timer (
      .clk       (clk),
      .rst       (rst),
      .win_end_o (win_end)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         tpe_edge_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) i_cnt (
            .clk       (clk),
            .rst       (rst),
            .probe_i   (probe_i[c]),
            .win_end_i (win_end),
            .live_o    (live_flat[c*CNT_W +: CNT_W]),
            .snap_o    (snap_flat[c*CNT_W +: CNT_W])
         );
      end
   endgenerate

   tpe_mac #(
      .NUM_CH   (NUM_CH),
      .CNT_W    (CNT_W),
      .WGT_W    (WGT_W),
      .WGT_FRAC (WGT_FRAC),
      .OUT_W    (OUT_W),
      .MUL_W    (MUL_W),
      .RECIP    (RECIP)
   ) i_mac (
      .clk      (clk),
      .rst      (rst),
      .start_i  (win_end),
      .snap_i   (snap_flat),
      .cap_w_i  (cap_w_i),
      .vdd2_w_i (vdd2_w_i),
      .freq_w_i (freq_w_i),
      .corr_w_i (corr_w_i),
      .busy_o   (busy),
      .power_o  (power_o),
      .valid_o  (power_valid_o)
   );
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned WIN_CYCLES = 1000,
   parameter int unsigned OUT_W      = 64
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    win_end,
   input logic                    busy,
   input logic [NUM_CH*CNT_W-1:0] live_flat,
   input logic [NUM_CH*CNT_W-1:0] snap_flat,
   input logic [OUT_W-1:0]        power_o,
   input logic                    power_valid_o
);
   // R2
   live_clear_chk: assert property (@(posedge clk) disable iff (rst)
      win_end |=> (live_flat == '0));

   // R2
   win_gap_chk: assert property (@(posedge clk) disable iff (rst)
      win_end |=> !win_end);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      power_valid_o |=> !power_valid_o);

   // R7
   power_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !power_valid_o |-> $stable(power_o));

   // R7
   valid_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
      power_valid_o |-> $past(busy));

   // R8
   reset_out_chk: assert property (@(posedge clk)
      rst |=> (power_o == '0 && !power_valid_o));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_bound
         // R9
         snap_bound_chk: assert property (@(posedge clk) disable iff (rst)
            snap_flat[c*CNT_W +: CNT_W] <= CNT_W'(WIN_CYCLES));
      end
   endgenerate
endmodule

bind toggle_power_est tpe_checker #(
   .NUM_CH     (NUM_CH),
   .CNT_W      (CNT_W),
   .WIN_CYCLES (WIN_CYCLES),
   .OUT_W      (OUT_W)
) i_tpe_checker (
   .clk           (clk),
   .rst           (rst),
   .win_end       (win_end),
   .busy          (busy),
   .live_flat     (live_flat),
   .snap_flat     (snap_flat),
   .power_o       (power_o),
   .power_valid_o (power_valid_o)
);

// File: tb/test_toggle_power_est.sv
module test_toggle_power_est;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NUM_CH     = 4;
   localparam int unsigned WIN        = 200;
   localparam int unsigned WW         = 16;
   localparam int unsigned AF         = $clog2(WIN) + 8;
   localparam longint unsigned RCP    = ((64'd1 << AF) + 64'(WIN / 2)) / 64'(WIN);

   typedef struct {
      logic [63:0] pw;
      longint      stamp;
   } item_t;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [NUM_CH-1:0]    probe = 4'b1011;
   logic [NUM_CH*WW-1:0] cap_w;
   logic [WW-1:0]        vdd2_w;
   logic [WW-1:0]        freq_w;
   logic [NUM_CH*WW-1:0] corr_w;
   logic [63:0]          power;
   logic                 pvalid;

   int     n_tests = 0;
   int     n_fail  = 0;
   longint cyc     = 0;
   int     cnt [NUM_CH];
   logic [NUM_CH-1:0] prev;
   int     wcyc = 0;
   item_t  q[$];
   logic [15:0] lfsr = 16'hACE1;
   int     tick = 0;

   toggle_power_est #(
      .NUM_CH     (NUM_CH),
      .WIN_CYCLES (WIN),
      .WGT_W      (WW),
      .WGT_FRAC   (8),
      .OUT_W      (64),
      .SATURATE   (1'b1)
   ) i_toggle_power_est (
      .clk           (clk),
      .rst           (rst),
      .probe_i       (probe),
      .cap_w_i       (cap_w),
      .vdd2_w_i      (vdd2_w),
      .freq_w_i      (freq_w),
      .corr_w_i      (corr_w),
      .power_o       (power),
      .power_valid_o (pvalid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [63:0] expect_power(input int c0, input int c1,
                                                input int c2, input int c3);
      int cs [NUM_CH];
      logic [127:0] x;
      logic [127:0] sum;
      cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
      sum = '0;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         // R4 activity, R5 stage order and truncating shifts
         x = 128'(cs[c]) * 128'(RCP);
         x = (x * 128'(cap_w[c*WW +: WW])) >> 8;
         x = (x * 128'(vdd2_w)) >> 8;
         x = (x * 128'(freq_w)) >> 8;
         x = (x * 128'(corr_w[c*WW +: WW])) >> 8;
         sum = sum + x;   // R6
      end
      return sum[63:0];
   endfunction

   // reference model: pushes the expected estimate for each closed window
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (rst) begin
         prev = probe;   // R3
         wcyc = 0;
         for (int c = 0; c < int'(NUM_CH); c++) cnt[c] = 0;
      end else begin
         for (int c = 0; c < int'(NUM_CH); c++) begin
            if (probe[c] != prev[c]) cnt[c] = cnt[c] + 1;   // R1
         end
         prev = probe;
         wcyc = wcyc + 1;
         if (wcyc == int'(WIN)) begin   // R2
            item_t it;
            it.pw    = expect_power(cnt[0], cnt[1], cnt[2], cnt[3]);
            it.stamp = cyc;
            q.push_back(it);
            wcyc = 0;
            for (int c = 0; c < int'(NUM_CH); c++) cnt[c] = 0;
         end
      end
   end

   // monitor: compares each strobed estimate with the queued expectation
   always @(negedge clk) begin
      if (!rst && pvalid) begin
         item_t it;
         n_tests++;
         if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R7: unexpected strobe, actual power=%0d expected no strobe", power);
         end else begin
            it = q.pop_front();
            if (power !== it.pw) begin
               n_fail++;
               $display("FAIL R6: power actual=%0d expected=%0d", power, it.pw);
            end
            n_tests++;
            if (cyc != it.stamp + longint'(NUM_CH)) begin
               n_fail++;
               $display("FAIL R7: strobe cycle actual=%0d expected=%0d",
                        cyc, it.stamp + longint'(NUM_CH));
            end
         end
      end
   end

   task automatic drive(input int mode, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick++;
         case (mode)
            1: probe[0] = ~probe[0];                       // R9 full rate
            2: for (int c = 0; c < int'(NUM_CH); c++)
                  if ((tick % (c + 1)) == 0) probe[c] = ~probe[c];
            3: begin
                  lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                  probe = lfsr[3:0];
               end
            default: ;
         endcase
      end
   endtask

   // change weights only well inside a window, after a strobe
   task automatic settle_then(output bit ok);
      @(negedge clk iff pvalid);
      repeat (2) @(negedge clk);
      ok = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R7: watchdog expired, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit ok;
      cap_w  = {16'h0100, 16'h0180, 16'h0200, 16'h0100};
      vdd2_w = 16'h0100;
      freq_w = 16'h0100;
      corr_w = {NUM_CH{16'h0100}};

      repeat (4) @(negedge clk);
      // R8 reset state
      n_tests++;
      if (power !== 64'd0) begin
         n_fail++;
         $display("FAIL R8: power in reset actual=%0d expected=0", power);
      end
      n_tests++;
      if (pvalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: strobe in reset actual=%0b expected=0", pvalid);
      end
      rst = 1'b0;
      // R8 first cycle after release
      @(negedge clk);
      n_tests++;
      if (power !== 64'd0 || pvalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: after release actual=%0d/%0b expected=0/0", power, pvalid);
      end

      // R3 steady non-zero probe through release: zero estimate expected
      drive(0, 2 * WIN);
      // R9 channel 0 toggling at every edge, R2 boundary edges included
      drive(1, 2 * WIN);
      // R1 divided rates per channel
      drive(2, 3 * WIN);
      // R10 scale one correction multiplier and the shared weights
      settle_then(ok);
      corr_w[1*WW +: WW] = 16'h0200;
      vdd2_w = 16'h0180;
      drive(2, 2 * WIN);
      settle_then(ok);
      freq_w = 16'h0340;
      corr_w[3*WW +: WW] = 16'h0280;
      // R1 pseudo-random activity on all channels
      drive(3, 4 * WIN);
      drive(0, WIN + 20);

      // R7 every expected estimate was strobed out
      @(negedge clk iff pvalid);
      repeat (3) @(negedge clk);
      n_tests++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R7: pending estimates actual=%0d expected=0", q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule